// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block supplies the control memory of a microprogrammed control unit with the address of the next microinstruction. It has a control address register whose value is the memory address. On every rising clock edge that register takes a new value from one of four places: its own value plus one, the branch target field of the current microinstruction, a one-entry return register, or an address produced outside the block from the machine opcode.

The current microinstruction supplies three fields. A condition code picks one status bit to test, and code zero stands for "always true". A two-bit branch operation combines that test result into a source choice and into a load strobe for the return register. The four branch operations are conditional jump, conditional call, return and opcode map. A call saves the address that follows the calling microinstruction, and a later return resumes there. Only one level of subroutine nesting is supported.

The block has no buffering. The microinstruction fields and the status bits must be valid before each clock edge. The new address is visible on the output one register delay after that edge.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the control address and the return register both become 0. A return issued right after reset therefore goes to address 0.
- R2: With branch operation 00 (jump), a true test loads `addr_field`. A false test loads the control address plus one.
- R3: Condition code 0 always tests true. Condition code k (1 to 3) tests `status[k-1]`, and that bit must be 1 for the test to be true.
- R4: With branch operation 01 (call) and a true test, the control address loads `addr_field` and the return register captures the old control address plus one. With a false test, the control address increments and the return register keeps its value.
- R5: With branch operation 10 (return), the control address loads the return register whatever the test result is, and the return register is left unchanged.
- R6: With branch operation 11 (map), the control address loads `map_addr` whatever the test result is.
- R7: The incrementer wraps modulo 2^AW. Stepping from all-ones gives 0, and a call made from address all-ones saves 0.
- R8: Jump, return, map and a not-taken call leave the return register unchanged. A later return shows this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_sel | input | 2 | Condition code of the current microinstruction |
| br_op | input | 2 | Branch operation of the current microinstruction |
| addr_field | input | AW (7) | Branch target field of the current microinstruction |
| map_addr | input | AW (7) | Externally mapped opcode entry address |
| status | input | 3 | Status bits that can be tested |
| cm_addr | output | AW (7) | Control memory address (the control address register) |

## Verification
The assertions take for granted that the microinstruction fields, the status bits and the mapped address are known values, held steady through each rising edge. They also take for granted that every condition code names an existing status input. The stimulus changes inputs only on falling edges and uses condition codes 0 to 3 against three status bits, so it stays inside those limits. The same holds for directed sequences and for the long random stretch. The directed sequences cover each branch operation with the test both true and false, call and return pairs, and wrap at the top of the address space. Each one is compared against a behavioural model on every clock.

// File: rtl/useq_pkg.sv
// Package: shared encodings for the next-address sequencer.
// Assumes: two-bit source select and two-bit branch operation encodings.
package useq_pkg;

    // Source feeding the control address register; the code is fixed by the mux.
    typedef enum logic [1:0] {
        SRC_INC   = 2'b00,
        SRC_FIELD = 2'b01,
        SRC_RET   = 2'b10,
        SRC_MAP   = 2'b11
    } src_sel_e;

    // Branch operation carried by the microinstruction.
    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_op_e;

    // Control produced by the input logic for one cycle.
    typedef struct packed {
        src_sel_e src;
        logic     ret_load;
    } nxt_ctl_t;

endpackage

// File: rtl/useq_cond_mux.sv
// Module: condition multiplexer.
// Selects one status bit for testing. Entry 0 is tied high so that branch
// operations can be made unconditional.
// Assumes: NCOND is a power of two and at least 2, so every code is a valid entry.
module useq_cond_mux #(
    parameter  int NCOND = 4,
    localparam int CSW   = $clog2(NCOND)
) (
    input  logic [CSW-1:0]   cond_sel,
    input  logic [NCOND-2:0] status,
    output logic             test
);

    logic [NCOND-1:0] cand;

    // Entry 0 is the constant "always" condition.
    assign cand[0] = 1'b1;

    // Entries 1..NCOND-1 come from the status inputs.
    for (genvar gi = 1; gi < NCOND; gi++) begin : g_cand
        assign cand[gi] = status[gi-1];
    end

    // Route the selected candidate to the test output.
    assign test = cand[cond_sel];

endmodule

// File: rtl/useq_input_logic.sv
// Module: input logic of the sequencer.
// Turns the branch operation and the test result into a source select and a
// return-register load strobe.
// Assumes: purely combinational; the fields are stable before the clock edge.
module useq_input_logic
    import useq_pkg::*;
(
    input  br_op_e   br_op,
    input  logic     test,
    output nxt_ctl_t ctl
);

    // Decode one branch operation per cycle.
    always_comb begin
        ctl.src      = SRC_INC;
        ctl.ret_load = 1'b0;
        unique case (br_op)
            BR_JUMP: ctl.src = test ? SRC_FIELD : SRC_INC;
            BR_CALL: begin
                ctl.src      = test ? SRC_FIELD : SRC_INC;
                ctl.ret_load = test;
            end
            BR_RET:  ctl.src = SRC_RET;
            BR_MAP:  ctl.src = SRC_MAP;
            default: ctl.src = SRC_INC;
        endcase
    end

endmodule

// File: rtl/useq_addr_path.sv
// Module: address path.
// Holds the control address register, the incrementer, the four-way source
// mux and the single-entry return register.
// Assumes: synchronous active-low reset; the incrementer wraps modulo 2^AW.
module useq_addr_path
    import useq_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  nxt_ctl_t      ctl,
    input  logic [AW-1:0] addr_field,
    input  logic [AW-1:0] map_addr,
    output logic [AW-1:0] car_q,
    output logic [AW-1:0] sbr_q
);

    logic [AW-1:0] car_inc;
    logic [AW-1:0] car_d;

    // Incrementer; the carry out is dropped so the count wraps.
    assign car_inc = car_q + 1'b1;

    // Four-way source mux in front of the control address register.
    always_comb begin
        unique case (ctl.src)
            SRC_INC:   car_d = car_inc;
            SRC_FIELD: car_d = addr_field;
            SRC_RET:   car_d = sbr_q;
            SRC_MAP:   car_d = map_addr;
            default:   car_d = car_inc;
        endcase
    end

    // Control address register.
    always_ff @(posedge clk) begin
        if (!rst_n) car_q <= '0;
        else        car_q <= car_d;
    end

    // Return register: captures the incremented address on a taken call.
    always_ff @(posedge clk) begin
        if (!rst_n)            sbr_q <= '0;
        else if (ctl.ret_load) sbr_q <= car_inc;
    end

endmodule

// File: rtl/useq_next_addr.sv
// Module: top of the microprogram next-address sequencer.
// Ties the condition mux, the input logic and the address path together.
// The output is the control address register itself.
// Assumes: the microinstruction fields come from the control memory word
// currently addressed and are valid before each rising edge.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter  int AW    = 7,
    parameter  int NCOND = 4,
    localparam int CSW   = $clog2(NCOND)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CSW-1:0]   cond_sel,
    input  logic [1:0]       br_op,
    input  logic [AW-1:0]    addr_field,
    input  logic [AW-1:0]    map_addr,
    input  logic [NCOND-2:0] status,
    output logic [AW-1:0]    cm_addr
);

    logic          test_bit;
    nxt_ctl_t      ctl;
    logic [AW-1:0] car_q;
    logic [AW-1:0] sbr_q;

    // Pick the status bit named by the condition code.
    useq_cond_mux #(.NCOND(NCOND)) u_cond (
        .cond_sel (cond_sel),
        .status   (status),
        .test     (test_bit)
    );

    // Combine the test result with the branch operation.
    useq_input_logic u_logic (
        .br_op (br_op_e'(br_op)),
        .test  (test_bit),
        .ctl   (ctl)
    );

    // Registers, incrementer and source mux.
    useq_addr_path #(.AW(AW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .addr_field (addr_field),
        .map_addr   (map_addr),
        .car_q      (car_q),
        .sbr_q      (sbr_q)
    );

    // The control address register drives the memory address directly.
    assign cm_addr = car_q;

endmodule

// File: rtl/useq_next_addr_chk.sv
// Module: assertion checker for the next-address sequencer, bound to the top.
// Assumes: inputs are known and held across each rising edge.
module useq_next_addr_chk #(
    parameter  int AW    = 7,
    parameter  int NCOND = 4,
    localparam int CSW   = $clog2(NCOND)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CSW-1:0]   cond_sel,
    input logic [1:0]       br_op,
    input logic [AW-1:0]    addr_field,
    input logic [AW-1:0]    map_addr,
    input logic [NCOND-2:0] status,
    input logic [AW-1:0]    cm_addr,
    input logic [AW-1:0]    sbr_q
);

    logic [NCOND-1:0] cond_vec;
    logic             t_ok;

    // Independent view of the tested condition.
    assign cond_vec = {status, 1'b1};
    assign t_ok     = cond_vec[cond_sel];

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cm_addr == '0 && sbr_q == '0));

    assert_jump_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_op == 2'b00 && t_ok) |=> cm_addr == $past(addr_field));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_op[1] == 1'b0 && !t_ok) |=> cm_addr == AW'($past(cm_addr) + 1'b1));

    assert_call_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_op == 2'b01 && t_ok) |=> (sbr_q == AW'($past(cm_addr) + 1'b1)
                                      && cm_addr == $past(addr_field)));

    assert_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_op == 2'b10) |=> cm_addr == $past(sbr_q));

    assert_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_op == 2'b11) |=> cm_addr == $past(map_addr));

    assert_ret_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_op == 2'b01 && t_ok) |=> $stable(sbr_q));

endmodule

bind useq_next_addr useq_next_addr_chk #(.AW(AW), .NCOND(NCOND)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_sel   (cond_sel),
    .br_op      (br_op),
    .addr_field (addr_field),
    .map_addr   (map_addr),
    .status     (status),
    .cm_addr    (cm_addr),
    .sbr_q      (sbr_q)
);

// File: tb/useq_next_addr_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared with the design on every clock.
module useq_next_addr_test;

    localparam int AW = 7;
    localparam int M  = 1 << AW;
    localparam int TOP = M - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cond_sel = '0;
    logic [1:0]    br_op = '0;
    logic [AW-1:0] addr_field = '0;
    logic [AW-1:0] map_addr = '0;
    logic [2:0]    status = '0;
    logic [AW-1:0] cm_addr;

    int checks = 0;
    int failures = 0;
    int m_car = 0;
    int m_ret = 0;
    bit done = 0;

    useq_next_addr uut (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_op(br_op),
        .addr_field(addr_field), .map_addr(map_addr), .status(status),
        .cm_addr(cm_addr)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one microinstruction, advance the model and compare after the edge.
    task automatic step(string req, bit rn, int cs, int br, int af, int ma, int st);
        bit t;
        int inc;
        rst_n = rn; cond_sel = 2'(cs); br_op = 2'(br);
        addr_field = AW'(af); map_addr = AW'(ma); status = 3'(st);
        t   = (cs == 0) ? 1'b1 : st[cs-1];
        inc = (m_car + 1) % M;
        if (!rn) begin
            m_car = 0; m_ret = 0;
        end else begin
            case (br)
                0: m_car = t ? af : inc;
                1: begin
                    if (t) m_ret = inc;
                    m_car = t ? af : inc;
                end
                2: m_car = m_ret;
                default: m_car = ma;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(req, int'(cm_addr), m_car);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1 reset", 0, 0, 0, 9, 9, 0);
        step("R1 reset hold", 0, 1, 1, 33, 0, 7);
        // R2: unconditional and conditional jumps.
        step("R2 jump always", 1, 0, 0, 5, 0, 0);
        step("R2 jump not taken", 1, 1, 0, 40, 0, 3'b110);
        step("R2 jump taken", 1, 1, 0, 40, 0, 3'b001);
        // R3: each condition code sees its own status bit.
        step("R3 code2 false", 1, 2, 0, 20, 0, 3'b101);
        step("R3 code2 true", 1, 2, 0, 20, 0, 3'b010);
        step("R3 code3 false", 1, 3, 0, 90, 0, 3'b011);
        step("R3 code3 true", 1, 3, 0, 90, 0, 3'b100);
        // R4/R5: call then return to caller plus one.
        step("R4 call taken", 1, 0, 1, 64, 0, 0);
        step("R2 step in sub", 1, 1, 0, 0, 0, 0);
        step("R5 return", 1, 1, 2, 3, 0, 0);
        // R4/R8: not-taken call keeps the saved address.
        step("R4 call not taken", 1, 2, 1, 100, 0, 0);
        step("R6 map test false", 1, 1, 3, 0, 77, 0);
        step("R6 map test true", 1, 0, 3, 0, 12, 0);
        step("R8 return after non-calls", 1, 0, 2, 0, 0, 0);
        // R7: wrap of the incrementer and of the saved address.
        step("R2 jump to top", 1, 0, 0, TOP, 0, 0);
        step("R7 wrap step", 1, 1, 0, 3, 0, 0);
        step("R2 jump to top", 1, 0, 0, TOP, 0, 0);
        step("R7 call from top", 1, 0, 1, 50, 0, 0);
        step("R7 return to wrapped", 1, 0, 2, 0, 0, 0);
        // R1: mid-run reset clears the return register.
        step("R4 call before reset", 1, 0, 1, 30, 0, 0);
        step("R1 mid reset", 0, 0, 0, 0, 0, 0);
        step("R1 return after reset", 1, 0, 2, 0, 0, 0);
        // Mixed random stretch, tagged by operation.
        for (int i = 0; i < 400; i++) begin
            int br = $urandom_range(0, 3);
            string tag;
            case (br)
                0: tag = "R2 random jump";
                1: tag = "R4 random call";
                2: tag = "R5 random return";
                default: tag = "R6 random map";
            endcase
            step(tag, ($urandom_range(0, 49) != 0), $urandom_range(0, 3), br,
                 $urandom_range(0, TOP), $urandom_range(0, TOP), $urandom_range(0, 7));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule